// File: doc/BRIEF.md
# X-of-Y Redundant Channel Voter

The voter takes the results of Y redundant channels and reduces them to one output that downstream logic can trust. Each channel presents a data word, a valid flag and a diagnostic-fault flag. When the vote strobe is high, the block groups the channels that may take part by the value they carry. The largest group wins if it has at least X members and no group of the same size holds a different value. X and Y are parameters, so one design covers arrangements such as 1oo1, 1oo2 with diagnostics, and 2oo3.

A channel that is outvoted, invalid or excluded by its diagnostic flag is marked in a per-channel disagreement mask. Voting goes on with the remaining channels, and the degraded flag reports that redundancy is reduced. Once the channel agrees again, its mark clears on the next strobe, so it can be repaired while the process keeps running. If the channels ever fail to reach a quorum, the block drops its valid flag and raises a safe-state request that only reset removes.

A small state machine holds the operating condition. ST_WAIT is the state after reset, before any vote. ST_OK means a vote passed with every channel agreeing. ST_DEGR means a vote passed with at least one channel marked. ST_SAFE means quorum was lost. From ST_WAIT, ST_OK or ST_DEGR, each strobe moves the machine to ST_SAFE on a failed vote, to ST_OK on a passed vote with an empty mask, and to ST_DEGR otherwise. ST_SAFE has no exit except reset.

Top module: `xy_voter`

## Requirements
- R1: A channel takes part in the vote only when its valid flag is 1 and, if USE_DIAG is 1, its diagnostic-fault flag is 0. With USE_DIAG at 0 the diagnostic flags have no effect. Channel i uses ch_data bits [i*DATA_W +: DATA_W] and flag bit i.
- R2: A vote passes when the largest set of participating channels holding an identical word has at least MIN_AGREE members and no participating channel outside that set belongs to an equally large set. The voted word is the one held by that set.
- R3: voted_data, voted_valid, degraded, safe_req and disagree_mask change only at a rising edge where vote_stb is sampled high, and show the result right after that edge. Without a strobe they hold their values.
- R4: After a passed vote, bit i of disagree_mask is 1 when channel i did not take part or carries a word different from the voted word. After a failed vote every mask bit is 1.
- R5: voted_valid is 1 in ST_OK and ST_DEGR. degraded is 1 only in ST_DEGR, which the machine enters when a vote passes with a nonzero mask.
- R6: A failed vote forces ST_SAFE. In that state voted_valid is 0, safe_req is 1 and voted_data is 0 until reset, even if later votes pass. The mask still updates on each strobe.
- R7: A channel that was marked is cleared from the mask on the first strobe where it participates and agrees. The state then returns from ST_DEGR to ST_OK with no loss of voted_valid.
- R8: During and after reset, with no strobe yet: voted_valid, degraded and safe_req are 0, and voted_data and disagree_mask are 0.
- R9: Faults that hit different channels at different times do not interrupt a valid output, as long as each vote still meets R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| vote_stb | input | 1 | Evaluate the channels at this edge |
| ch_data | input | NUM_CH*DATA_W | Per-channel data words, channel 0 in the low bits |
| ch_valid | input | NUM_CH | Per-channel valid flags |
| ch_diag | input | NUM_CH | Per-channel diagnostic-fault flags |
| voted_data | output | DATA_W | Registered voted word |
| voted_valid | output | 1 | Voted word may be used |
| disagree_mask | output | NUM_CH | Channels outvoted or excluded at the last strobe |
| degraded | output | 1 | Output valid with at least one channel marked |
| safe_state_req | output | 1 | Quorum lost, held until reset |

## Verification
The bench builds two instances. The first uses NUM_CH=3, MIN_AGREE=2 and USE_DIAG=1, a two-of-three voter. On it, single outvoted channels, invalid channels, diagnostic exclusion, repair and faults moving from channel to channel all stay within reach, and a three-way split can drive the block into ST_SAFE. The second uses NUM_CH=2, MIN_AGREE=1 and USE_DIAG=1, which exercises the case where a diagnostic flag settles a disagreement and the case where an unresolved one-against-one tie must fail the vote.

// File: rtl/voter_pkg.sv
package voter_pkg;
    typedef enum logic [1:0] {
        ST_WAIT = 2'd0,
        ST_OK   = 2'd1,
        ST_DEGR = 2'd2,
        ST_SAFE = 2'd3
    } vote_state_t;
endpackage

// File: rtl/voter_match.sv
// Counts, for every participating channel, how many participating channels
// (itself included) carry an identical word.
module voter_match #(
    parameter int NUM_CH = 3,
    parameter int DATA_W = 8,
    parameter int CW     = 2
) (
    input  logic [NUM_CH*DATA_W-1:0] data,
    input  logic [NUM_CH-1:0]        elig,
    output logic [NUM_CH*CW-1:0]     agree_cnt
);
    for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_ch
        logic [CW-1:0] cnt;
        always_comb begin
            cnt = '0;
            if (elig[gi]) begin
                for (int j = 0; j < NUM_CH; j++) begin
                    if (elig[j] && data[j*DATA_W +: DATA_W] == data[gi*DATA_W +: DATA_W])
                        cnt = cnt + CW'(1);
                end
            end
        end
        assign agree_cnt[gi*CW +: CW] = cnt;
    end
endmodule

// File: rtl/voter_select.sv
// Picks the largest agreeing group, rejects ties and short quorums,
// and forms the per-channel disagreement mask.
module voter_select #(
    parameter int NUM_CH    = 3,
    parameter int DATA_W    = 8,
    parameter int CW        = 2,
    parameter int MIN_AGREE = 2
) (
    input  logic [NUM_CH*DATA_W-1:0] data,
    input  logic [NUM_CH-1:0]        elig,
    input  logic [NUM_CH*CW-1:0]     agree_cnt,
    output logic                     win_ok,
    output logic [DATA_W-1:0]        win_data,
    output logic [NUM_CH-1:0]        mask
);
    logic [CW-1:0] best_cnt;
    logic          tie;

    always_comb begin
        best_cnt = '0;
        win_data = data[DATA_W-1:0];
        for (int i = 0; i < NUM_CH; i++) begin
            if (elig[i] && agree_cnt[i*CW +: CW] > best_cnt) begin
                best_cnt = agree_cnt[i*CW +: CW];
                win_data = data[i*DATA_W +: DATA_W];
            end
        end
        tie = 1'b0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (elig[i] && agree_cnt[i*CW +: CW] == best_cnt &&
                data[i*DATA_W +: DATA_W] != win_data)
                tie = 1'b1;
        end
        win_ok = (best_cnt >= CW'(MIN_AGREE)) && !tie;
        for (int i = 0; i < NUM_CH; i++) begin
            mask[i] = win_ok ? (!elig[i] || data[i*DATA_W +: DATA_W] != win_data) : 1'b1;
        end
    end
endmodule

// File: rtl/voter_fsm.sv
// Operating-condition state machine plus the registered vote results.
module voter_fsm
    import voter_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vote_stb,
    input  logic              win_ok,
    input  logic [DATA_W-1:0] win_data,
    input  logic [NUM_CH-1:0] mask_in,
    output logic [DATA_W-1:0] voted_data,
    output logic              voted_valid,
    output logic              degraded,
    output logic              safe_state_req,
    output logic [NUM_CH-1:0] disagree_mask
);
    vote_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT, ST_OK, ST_DEGR: begin
                if (vote_stb) begin
                    if (!win_ok)            state_d = ST_SAFE;
                    else if (mask_in == '0) state_d = ST_OK;
                    else                    state_d = ST_DEGR;
                end
            end
            ST_SAFE: state_d = ST_SAFE;
            default: state_d = ST_SAFE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_WAIT;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            voted_data    <= '0;
            disagree_mask <= '0;
        end else if (vote_stb) begin
            disagree_mask <= mask_in;
            voted_data    <= (state_d == ST_SAFE) ? '0 : win_data;
        end
    end

    always_comb begin
        voted_valid    = 1'b0;
        degraded       = 1'b0;
        safe_state_req = 1'b0;
        unique case (state_q)
            ST_WAIT: ;
            ST_OK:   voted_valid = 1'b1;
            ST_DEGR: begin
                voted_valid = 1'b1;
                degraded    = 1'b1;
            end
            ST_SAFE: safe_state_req = 1'b1;
            default: safe_state_req = 1'b1;
        endcase
    end

    assert_safe_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        safe_state_req |=> safe_state_req);
    assert_fail_to_safe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (vote_stb && !win_ok) |=> (safe_state_req && !voted_valid && voted_data == '0));
    assert_valid_excl_safe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(voted_valid && safe_state_req));
    assert_degraded_needs_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        degraded |-> (voted_valid && disagree_mask != '0));
    assert_clean_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (voted_valid && !degraded) |-> disagree_mask == '0);
    assert_hold_no_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !vote_stb |=> ($stable(disagree_mask) && $stable(voted_data)));
endmodule

// File: rtl/xy_voter.sv
module xy_voter #(
    parameter int NUM_CH    = 3,
    parameter int MIN_AGREE = 2,
    parameter int DATA_W    = 8,
    parameter bit USE_DIAG  = 1'b1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     vote_stb,
    input  logic [NUM_CH*DATA_W-1:0] ch_data,
    input  logic [NUM_CH-1:0]        ch_valid,
    input  logic [NUM_CH-1:0]        ch_diag,
    output logic [DATA_W-1:0]        voted_data,
    output logic                     voted_valid,
    output logic [NUM_CH-1:0]        disagree_mask,
    output logic                     degraded,
    output logic                     safe_state_req
);
    localparam int CW = $clog2(NUM_CH + 1);

    logic [NUM_CH-1:0]    elig;
    logic [NUM_CH*CW-1:0] agree_cnt;
    logic                 win_ok;
    logic [DATA_W-1:0]    win_data;
    logic [NUM_CH-1:0]    mask_c;

    if (USE_DIAG) begin : g_diag
        assign elig = ch_valid & ~ch_diag;
    end else begin : g_nodiag
        assign elig = ch_valid;
    end

    voter_match #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .CW(CW)) u_match (
        .data(ch_data), .elig(elig), .agree_cnt(agree_cnt)
    );

    voter_select #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .CW(CW), .MIN_AGREE(MIN_AGREE)) u_select (
        .data(ch_data), .elig(elig), .agree_cnt(agree_cnt),
        .win_ok(win_ok), .win_data(win_data), .mask(mask_c)
    );

    voter_fsm #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .vote_stb(vote_stb),
        .win_ok(win_ok), .win_data(win_data), .mask_in(mask_c),
        .voted_data(voted_data), .voted_valid(voted_valid),
        .degraded(degraded), .safe_state_req(safe_state_req),
        .disagree_mask(disagree_mask)
    );

    assert_excluded_marked_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (vote_stb && win_ok) |=> ((disagree_mask & $past(~elig)) == $past(~elig)));
endmodule

// File: tb/test_xy_voter.sv
module test_xy_voter;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stb = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    // two-of-three instance
    logic [23:0] a_data = '0;
    logic [2:0]  a_vld = '1, a_dg = '0;
    logic [7:0]  a_out;
    logic        a_v, a_deg, a_safe;
    logic [2:0]  a_mask;

    xy_voter #(.NUM_CH(3), .MIN_AGREE(2), .DATA_W(8), .USE_DIAG(1'b1)) i_xy_voter (
        .clk(clk), .rst_n(rst_n), .vote_stb(stb), .ch_data(a_data),
        .ch_valid(a_vld), .ch_diag(a_dg), .voted_data(a_out), .voted_valid(a_v),
        .disagree_mask(a_mask), .degraded(a_deg), .safe_state_req(a_safe)
    );

    // one-of-two with diagnostics instance
    logic [15:0] b_data = '0;
    logic [1:0]  b_vld = '1, b_dg = '0;
    logic [7:0]  b_out;
    logic        b_v, b_deg, b_safe;
    logic [1:0]  b_mask;

    xy_voter #(.NUM_CH(2), .MIN_AGREE(1), .DATA_W(8), .USE_DIAG(1'b1)) i_xy_voter_d (
        .clk(clk), .rst_n(rst_n), .vote_stb(stb), .ch_data(b_data),
        .ch_valid(b_vld), .ch_diag(b_dg), .voted_data(b_out), .voted_valid(b_v),
        .disagree_mask(b_mask), .degraded(b_deg), .safe_state_req(b_safe)
    );

    typedef struct packed {
        logic [7:0] d0, d1, d2;
        logic [2:0] vld, dg;
        logic [7:0] xd;
        logic       xv;
        logic [2:0] xm;
        logic       xdeg;
    } row_t;

    localparam row_t TBL [8] = '{
        '{8'h11, 8'h11, 8'h11, 3'b111, 3'b000, 8'h11, 1'b1, 3'b000, 1'b0}, // R2 unanimous
        '{8'h22, 8'h22, 8'h33, 3'b111, 3'b000, 8'h22, 1'b1, 3'b100, 1'b1}, // R4 ch2 outvoted
        '{8'h44, 8'h55, 8'h44, 3'b111, 3'b000, 8'h44, 1'b1, 3'b010, 1'b1}, // R4 ch1 outvoted
        '{8'h66, 8'h66, 8'h66, 3'b111, 3'b000, 8'h66, 1'b1, 3'b000, 1'b0}, // R7 repaired
        '{8'h77, 8'h77, 8'h77, 3'b110, 3'b000, 8'h77, 1'b1, 3'b001, 1'b1}, // R1 ch0 invalid
        '{8'h88, 8'h88, 8'h88, 3'b111, 3'b100, 8'h88, 1'b1, 3'b100, 1'b1}, // R1 ch2 diag
        '{8'h99, 8'h12, 8'h99, 3'b111, 3'b000, 8'h99, 1'b1, 3'b010, 1'b1}, // R9 later fault
        '{8'h5a, 8'h5a, 8'h5a, 3'b111, 3'b000, 8'h5a, 1'b1, 3'b000, 1'b0}  // R7 recovered
    };

    int n_cmp = 0;
    int n_bad = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic vote;
        @(negedge clk) stb = 1'b1;
        @(negedge clk) stb = 1'b0;
    endtask

    task automatic do_reset;
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk) rst_n = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        do_reset();
        // R8 reset state
        chk("R8 valid", a_v, 0);
        chk("R8 safe", a_safe, 0);
        chk("R8 degraded", a_deg, 0);
        chk("R8 data", a_out, 0);
        chk("R8 mask", a_mask, 0);

        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            a_data = {TBL[k].d2, TBL[k].d1, TBL[k].d0};
            a_vld  = TBL[k].vld;
            a_dg   = TBL[k].dg;
            vote();
            chk($sformatf("R2 row%0d data", k), a_out, TBL[k].xd);
            chk($sformatf("R5 row%0d valid", k), a_v, TBL[k].xv);
            chk($sformatf("R4 row%0d mask", k), a_mask, TBL[k].xm);
            chk($sformatf("R5 row%0d degraded", k), a_deg, TBL[k].xdeg);
            chk($sformatf("R9 row%0d safe", k), a_safe, 0);
        end

        // R3: changed inputs without a strobe leave the outputs alone
        a_data = {8'h01, 8'h02, 8'h03};
        repeat (3) @(negedge clk);
        chk("R3 hold data", a_out, 8'h5a);
        chk("R3 hold mask", a_mask, 0);
        chk("R3 hold valid", a_v, 1);

        // R6: three-way split loses quorum
        vote();
        chk("R6 safe", a_safe, 1);
        chk("R6 valid", a_v, 0);
        chk("R6 data", a_out, 0);
        chk("R4 fail mask", a_mask, 3'b111);
        a_data = {8'h11, 8'h11, 8'h11};
        vote();
        chk("R6 safe sticky", a_safe, 1);
        chk("R6 valid sticky", a_v, 0);
        chk("R6 data sticky", a_out, 0);
        chk("R6 mask updates", a_mask, 3'b000);

        do_reset();
        chk("R8 safe cleared", a_safe, 0);
        chk("R8 valid cleared", a_v, 0);

        // R2: two valid channels disagreeing, third invalid -> no quorum
        a_data = {8'h30, 8'h20, 8'h10};
        a_vld  = 3'b011;
        vote();
        chk("R2 split pair safe", a_safe, 1);
        do_reset();

        // one-of-two with diagnostics
        a_vld = 3'b111;
        a_data = '0;
        b_data = {8'h30, 8'h30};
        vote();
        chk("R2 1oo2 agree data", b_out, 8'h30);
        chk("R5 1oo2 agree degraded", b_deg, 0);
        b_data = {8'h31, 8'h30};
        b_dg   = 2'b10;
        vote();
        chk("R1 1oo2 diag data", b_out, 8'h30);
        chk("R4 1oo2 diag mask", b_mask, 2'b10);
        chk("R5 1oo2 diag degraded", b_deg, 1);
        b_data = {8'h41, 8'h40};
        b_dg   = 2'b00;
        vote();
        chk("R2 1oo2 tie safe", b_safe, 1);
        chk("R6 1oo2 tie valid", b_v, 0);
        chk("R4 1oo2 tie mask", b_mask, 2'b11);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule